// File: doc/BRIEF.md
# Transmit/Receive Word FIFO Pair with Self-Clearing Flush

This block sits between a small register interface and the bus engine of a packet-mode serial controller. Software writes 32-bit words into a transmit queue through a data port and reads 32-bit words out of a receive queue through a second data port. The engine consumes transmit words and deposits receive words. Each word carries four bytes in little-endian order. The block passes each word through unchanged.

A control register holds two 3-bit trigger levels and two flush bits. A flush bit stays set for one cycle after it is written and then clears itself, so software can poll it. A status register reports how many transmit slots are free and how many receive words are waiting. Two request outputs rise when the free transmit space or the filled receive space reaches its trigger level plus one. Misuse from software raises a one-cycle pulse: a write to a full transmit queue, or a read from an empty receive queue.

Registers are selected by `reg_addr`:
- 0 is control.
- 1 is status.
- 2 is the transmit data port, which is write-only and reads as 0.
- 3 is the receive data port.

Reads are combinational on `reg_addr`. Only a strobed read of address 3 pops a word.

Top module: `wfifo_pair`

## Requirements
- R1: After reset both queues are empty, every control field is 0, status reads 0x80, `tx_req` is 1, and `rx_req`, `tx_ovf` and `rx_unf` are 0.
- R2: Words written to address 2 appear on `tx_head` in write order. `tx_avail` is high while a word is present, and each `tx_pop` cycle advances to the next word.
- R3: Words pushed with `rx_push` are returned at address 3 in arrival order. Each strobed read of address 3 removes one word.
- R4: Status bits [7:4] give the free transmit slots and bits [3:0] give the filled receive slots. Each count saturates at 15, and the other bits read 0.
- R5: Control bit 1 is the transmit flush and bit 0 is the receive flush. Bits [4:2] are the receive trigger and bits [7:5] are the transmit trigger. All of these read back as written, apart from the flush self-clear.
- R6: A written flush bit reads 1 for exactly the next cycle. It then reads 0 and its queue is empty. The other queue and both triggers are unchanged. A push into that queue during the cycle the flush bit reads 1 is discarded.
- R7: `tx_req` is 1 exactly when the free transmit slots are at least the transmit trigger plus 1.
- R8: `rx_req` is 1 exactly when the filled receive slots are at least the receive trigger plus 1.
- R9: A write to address 2 while the transmit queue holds 8 words makes `tx_ovf` high for the next cycle only. Queue contents and order are unchanged.
- R10: A strobed read of address 3 with the receive queue empty makes `rx_unf` high for the next cycle only, and the count stays 0.
- R11: `rx_push` while the receive queue holds 8 words, and `tx_pop` while the transmit queue is empty, have no effect on contents or counts. `rx_room` is low while the receive queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 3) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_pop | input | 1 | Engine takes the head transmit word |
| tx_head | output | 32 | Head transmit word |
| tx_avail | output | 1 | Transmit queue holds a word |
| rx_push | input | 1 | Engine deposits a receive word |
| rx_data | input | 32 | Receive word from engine |
| rx_room | output | 1 | Receive queue can accept a word |
| tx_req | output | 1 | Transmit space at or above trigger |
| rx_req | output | 1 | Receive fill at or above trigger |
| tx_ovf | output | 1 | One-cycle transmit overflow pulse |
| rx_unf | output | 1 | One-cycle receive underflow pulse |

## Verification
Pointer or count corruption shows at the ports without delay. The status register and both request lines are combinational on the counts, so a wrong count appears in the same cycle it arises. A pointer that slips shows up as a wrong or reordered word at the next pop, which the scoreboard flags on that word. A flush that fails to clear, or clears late, is visible in the first control read after the write and in the status read one cycle later. A lost overflow or underflow is caught because each pulse is sampled in the single cycle it should occupy.

// File: rtl/wfp_pkg.sv
// Shared register selects and control-field positions for the word FIFO pair.
// Assumes a two-bit register address space.
package wfp_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_TXD  = 2'd2,
        SEL_RXD  = 2'd3
    } reg_sel_e;

    // Flush bits sit at fixed low positions; trigger fields follow them.
    localparam int unsigned CTL_RXFL_BIT = 0;
    localparam int unsigned CTL_TXFL_BIT = 1;
    localparam int unsigned CTL_TRIG_LSB = 2;
endpackage

// File: rtl/wfp_fifo.sv
// Synchronous word queue with a flush input.
// A push is accepted only when the queue is not full, and a pop only when it
// is not empty. A flush empties the queue and discards any push or pop in the
// same cycle. Refused push and pop each raise a one-cycle registered pulse.
// Assumes DEPTH >= 2.
module wfp_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     pdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             over,
    output logic             under
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];
    assign count   = cnt_q;

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= pdata;
    end

    // Advance or clear the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) cnt_q <= '0;
        else begin
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Register the misuse pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over  <= 1'b0;
            under <= 1'b0;
        end else begin
            over  <= push && full && !flush;
            under <= pop && empty && !flush;
        end
    end
endmodule

// File: rtl/wfp_ctrl.sv
// Control register: two trigger fields and two self-clearing flush flags.
// A write loads both triggers. A flush flag is high for exactly the cycle
// after the write that set it. Assumes the write strobe is a single cycle.
module wfp_ctrl #(
    parameter int unsigned TRIG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_txfl,
    input  logic              wr_rxfl,
    input  logic [TRIG_W-1:0] wr_txtrig,
    input  logic [TRIG_W-1:0] wr_rxtrig,
    output logic              txfl,
    output logic              rxfl,
    output logic [TRIG_W-1:0] tx_trig,
    output logic [TRIG_W-1:0] rx_trig
);
    // Hold the trigger levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_trig <= '0;
            rx_trig <= '0;
        end else if (wr) begin
            tx_trig <= wr_txtrig;
            rx_trig <= wr_rxtrig;
        end
    end

    // Flush flags live one cycle and then clear themselves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txfl <= 1'b0;
            rxfl <= 1'b0;
        end else begin
            txfl <= wr && wr_txfl;
            rxfl <= wr && wr_rxfl;
        end
    end
endmodule

// File: rtl/wfp_level.sv
// Occupancy reporting: saturated status counts and trigger comparisons.
// Purely combinational. The saturating path is generated only when DEPTH can
// exceed the status field.
module wfp_level #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned STAT_W = 4,
    parameter int unsigned TRIG_W = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned CMP_W = ((CNT_W > TRIG_W) ? CNT_W : TRIG_W) + 1,
    localparam int unsigned SAT   = (1 << STAT_W) - 1
) (
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic [TRIG_W-1:0] rx_trig,
    output logic [STAT_W-1:0] tx_free_st,
    output logic [STAT_W-1:0] rx_fill_st,
    output logic              tx_req,
    output logic              rx_req
);
    logic [CNT_W-1:0] tx_free;

    assign tx_free = CNT_W'(DEPTH) - tx_cnt;

    // Compare against trigger plus one in a width wide enough for both.
    assign tx_req = CMP_W'(tx_free) >= (CMP_W'(tx_trig) + CMP_W'(1));
    assign rx_req = CMP_W'(rx_cnt)  >= (CMP_W'(rx_trig) + CMP_W'(1));

    generate
        if (DEPTH > SAT) begin : g_sat
            // Clamp counts that overflow the status field.
            assign tx_free_st = (tx_free > CNT_W'(SAT)) ? '1 : STAT_W'(tx_free);
            assign rx_fill_st = (rx_cnt  > CNT_W'(SAT)) ? '1 : STAT_W'(rx_cnt);
        end else begin : g_plain
            assign tx_free_st = STAT_W'(tx_free);
            assign rx_fill_st = STAT_W'(rx_cnt);
        end
    endgenerate
endmodule

// File: rtl/wfifo_pair.sv
// Transmit/receive word FIFO pair behind a four-register interface.
// Decodes register strobes, routes flushes, and multiplexes read data.
// Reads are combinational on reg_addr. Only a strobed receive-port read pops.
// Assumes the status fields are narrow enough to fit two in 32 bits.
module wfifo_pair
    import wfp_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned TRIG_W = 3,
    parameter int unsigned STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_head,
    output logic              tx_avail,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_room,
    output logic              tx_req,
    output logic              rx_req,
    output logic              tx_ovf,
    output logic              rx_unf
);
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
    localparam int unsigned RXT_LSB = CTL_TRIG_LSB;
    localparam int unsigned TXT_LSB = CTL_TRIG_LSB + TRIG_W;

    logic              ctrl_wr, txd_wr, rxd_rd;
    logic              txfl, rxfl;
    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [STAT_W-1:0] tx_free_st, rx_fill_st;

    assign ctrl_wr  = reg_wr && (reg_addr == SEL_CTRL);
    assign txd_wr   = reg_wr && (reg_addr == SEL_TXD);
    assign rxd_rd   = reg_rd && (reg_addr == SEL_RXD);
    assign tx_avail = !tx_empty;
    assign rx_room  = !rx_full;

    wfp_ctrl #(.TRIG_W(TRIG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctrl_wr),
        .wr_txfl   (reg_wdata[CTL_TXFL_BIT]),
        .wr_rxfl   (reg_wdata[CTL_RXFL_BIT]),
        .wr_txtrig (reg_wdata[TXT_LSB +: TRIG_W]),
        .wr_rxtrig (reg_wdata[RXT_LSB +: TRIG_W]),
        .txfl      (txfl),
        .rxfl      (rxfl),
        .tx_trig   (tx_trig),
        .rx_trig   (rx_trig)
    );

    wfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (txfl),
        .push  (txd_wr),
        .pdata (reg_wdata),
        .pop   (tx_pop),
        .head  (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty),
        .over  (tx_ovf),
        .under ()
    );

    wfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rxfl),
        .push  (rx_push),
        .pdata (rx_data),
        .pop   (rxd_rd),
        .head  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty),
        .over  (),
        .under (rx_unf)
    );

    wfp_level #(.DEPTH(DEPTH), .STAT_W(STAT_W), .TRIG_W(TRIG_W)) u_lvl (
        .tx_cnt     (tx_cnt),
        .rx_cnt     (rx_cnt),
        .tx_trig    (tx_trig),
        .rx_trig    (rx_trig),
        .tx_free_st (tx_free_st),
        .rx_fill_st (rx_fill_st),
        .tx_req     (tx_req),
        .rx_req     (rx_req)
    );

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            SEL_CTRL: begin
                reg_rdata[CTL_RXFL_BIT]       = rxfl;
                reg_rdata[CTL_TXFL_BIT]       = txfl;
                reg_rdata[RXT_LSB +: TRIG_W]  = rx_trig;
                reg_rdata[TXT_LSB +: TRIG_W]  = tx_trig;
            end
            SEL_STAT: begin
                reg_rdata[0 +: STAT_W]        = rx_fill_st;
                reg_rdata[STAT_W +: STAT_W]   = tx_free_st;
            end
            SEL_RXD:  reg_rdata = rx_empty ? '0 : rx_head;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wfp_chk.sv
// Checker for wfifo_pair, attached by bind. Observes decoded strobes,
// flush flags and queue counts.
module wfp_chk #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             txd_wr,
    input logic             rxd_rd,
    input logic             tx_pop,
    input logic             rx_push,
    input logic             txfl,
    input logic             rxfl,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic             tx_ovf,
    input logic             rx_unf
);
    // R6
    tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txfl |=> (tx_cnt == '0));

    // R6
    rx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxfl |=> (rx_cnt == '0));

    // R6
    flush_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txfl && !ctrl_wr) |=> !txfl);

    // R9
    tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !tx_pop && !txfl && tx_cnt == CNT_W'(DEPTH))
        |=> (tx_ovf && tx_cnt == CNT_W'(DEPTH)));

    // R10
    rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_rd && !rx_push && !rxfl && rx_cnt == '0)
        |=> (rx_unf && rx_cnt == '0));

    // R2
    tx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !tx_pop && !txfl && tx_cnt < CNT_W'(DEPTH))
        |=> (tx_cnt == $past(tx_cnt) + 1'b1));

    // R11
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH));
endmodule

bind wfifo_pair wfp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .txd_wr  (txd_wr),
    .rxd_rd  (rxd_rd),
    .tx_pop  (tx_pop),
    .rx_push (rx_push),
    .txfl    (txfl),
    .rxfl    (rxfl),
    .tx_cnt  (tx_cnt),
    .rx_cnt  (rx_cnt),
    .tx_ovf  (tx_ovf),
    .rx_unf  (rx_unf)
);

// File: tb/sim_wfifo_pair.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected words, and a monitor compares
// them as the design presents them.
module sim_wfifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_pop = 1'b0, tx_avail, rx_push = 1'b0, rx_room;
    logic [31:0] tx_head, rx_data = '0;
    logic        tx_req, rx_req, tx_ovf, rx_unf;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];

    always #10 clk = ~clk;

    wfifo_pair u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare words leaving either queue against the scoreboard.
    always @(negedge clk) begin
        if (tx_pop && txq.size() > 0) begin
            check("R2 tx word order", tx_head, txq[0]);
            void'(txq.pop_front());
        end
        if (reg_rd && reg_addr == 2'd3 && rxq.size() > 0) begin
            check("R3 rx word order", reg_rdata, rxq[0]);
            void'(rxq.pop_front());
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic tx_write(input logic [31:0] d);
        if (txq.size() < 8) txq.push_back(d);
        reg_write(2'd2, d);
    endtask

    task automatic tx_take();
        tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
    endtask

    task automatic rx_give(input logic [31:0] d);
        if (rxq.size() < 8) rxq.push_back(d);
        rx_push = 1'b1; rx_data = d; cyc(); rx_push = 1'b0;
    endtask

    task automatic rx_take();
        reg_addr = 2'd3; reg_rd = 1'b1; cyc(); reg_rd = 1'b0;
    endtask

    task automatic ctrl_write(input logic [31:0] d);
        if (d[1]) txq.delete();
        if (d[0]) rxq.delete();
        reg_write(2'd0, d);
    endtask

    function automatic logic [31:0] peek(input logic [1:0] a);
        reg_addr = a;
        return reg_rdata;
    endfunction

    task automatic look(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        look("R1 status after reset", 2'd1, 32'h80);
        look("R1 control after reset", 2'd0, 32'h0);
        check("R1 tx_req/rx_req/ovf/unf", {28'd0, tx_req, rx_req, tx_ovf, rx_unf}, 32'b1000);

        // R2: basic transmit order and availability
        tx_write(32'h1111_0001); tx_write(32'h2222_0002); tx_write(32'h3333_0003);
        look("R4 tx free after 3 writes", 2'd1, 32'h50);
        check("R2 tx_avail", {31'd0, tx_avail}, 32'd1);
        repeat (3) tx_take();
        check("R2 tx_avail after drain", {31'd0, tx_avail}, 32'd0);
        // R11: pop from empty tx queue has no effect
        tx_take();
        look("R11 status after empty pop", 2'd1, 32'h80);

        // R9: overflow on full transmit queue
        for (int i = 0; i < 8; i++) tx_write(32'hA000_0000 + i);
        look("R4 tx full status", 2'd1, 32'h00);
        reg_write(2'd2, 32'hDEAD_BEEF);
        check("R9 tx_ovf pulse", {31'd0, tx_ovf}, 32'd1);
        look("R9 status unchanged", 2'd1, 32'h00);
        cyc();
        check("R9 tx_ovf one cycle", {31'd0, tx_ovf}, 32'd0);
        repeat (8) tx_take();
        check("R9 no extra word", {31'd0, tx_avail}, 32'd0);

        // R5/R7/R8: trigger levels (tx trig 4 at [7:5], rx trig 4 at [4:2])
        ctrl_write(32'h90);
        look("R5 control readback", 2'd0, 32'h90);
        for (int i = 0; i < 3; i++) tx_write(32'hB000_0000 + i);
        check("R7 tx_req free 5 trig 4", {31'd0, tx_req}, 32'd1);
        tx_write(32'hB000_0003);
        check("R7 tx_req free 4 trig 4", {31'd0, tx_req}, 32'd0);
        for (int i = 0; i < 4; i++) rx_give(32'hC000_0000 + i);
        check("R8 rx_req fill 4 trig 4", {31'd0, rx_req}, 32'd0);
        rx_give(32'hC000_0004);
        check("R8 rx_req fill 5 trig 4", {31'd0, rx_req}, 32'd1);
        look("R4 status mixed", 2'd1, 32'h45);

        // R6: transmit flush leaves receive side and triggers alone
        ctrl_write(32'h92);
        look("R6 tx flush bit pending", 2'd0, 32'h92);
        reg_write(2'd2, 32'hFEED_0000);  // discarded by the pending flush
        look("R6 tx flush bit cleared", 2'd0, 32'h90);
        look("R6 tx emptied, rx kept", 2'd1, 32'h85);
        check("R6 push during flush dropped", {31'd0, tx_avail}, 32'd0);

        // R3: read back part of the receive queue
        repeat (2) rx_take();
        look("R4 rx fill after reads", 2'd1, 32'h83);

        // R6: receive flush
        ctrl_write(32'h91);
        look("R6 rx flush bit pending", 2'd0, 32'h91);
        cyc();
        look("R6 rx emptied", 2'd1, 32'h80);
        check("R8 rx_req after flush", {31'd0, rx_req}, 32'd0);

        // R10: underflow on empty receive queue
        rx_take();
        check("R10 rx_unf pulse", {31'd0, rx_unf}, 32'd1);
        look("R10 rx count stays 0", 2'd1, 32'h80);
        cyc();
        check("R10 rx_unf one cycle", {31'd0, rx_unf}, 32'd0);
        rx_give(32'h5A5A_A5A5);
        rx_take();

        // R11: push into full receive queue is dropped
        for (int i = 0; i < 9; i++) rx_give(32'hD000_0000 + i);
        look("R11 rx fill capped", 2'd1, 32'h88);
        check("R11 rx_room when full", {31'd0, rx_room}, 32'd0);
        repeat (8) rx_take();
        look("R11 rx empty after drain", 2'd1, 32'h80);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule